// File: doc/BRIEF.md
# Power-Up Reset and Mute Sequencer

This controller steps a mixed-signal converter through start-up and shutdown. It watches an active-low external reset pin, a software power-down bit, a PLL-lock flag and a clock-source select. From these it drives a register-file reset, a control-port enable, a low-power enable, forced mutes for the serial ports and the converter outputs, and an enable for the serial audio outputs.

Leaving low power takes two steps. First the reset pin must be released. Then software must clear the power-down bit. After that a counter times out the reference settling delay, which is a parameter (about 80 ms of clock cycles on silicon, far fewer in simulation). When the PLL is the selected clock, the sequencer also waits for lock before it enables the serial outputs.

The states are RESET, CONFIG, RAMP, WAIT_PLL and RUN. The transitions are:
- RESET→CONFIG when the pin is released.
- CONFIG→RAMP when the power-down bit is cleared.
- RAMP→WAIT_PLL or RAMP→RUN when the count expires.
- WAIT_PLL→RUN on lock.
- Any state→RESET when the pin is asserted.
- RAMP, WAIT_PLL or RUN→CONFIG when the power-down bit is set again.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst_pin_n` is low, all of the following hold: `regs_rst` is 1, `ctl_port_en` is 0, `low_power` is 1, `port_mute` is 1, `conv_mute` is 1 and `sdout_en` is 0.
- R2: After `rst_pin_n` rises, the sequencer enters CONFIG on the next clock. In CONFIG, `regs_rst` is 0 and `ctl_port_en` is 1, while `low_power` and both mutes stay 1 for as long as `pd_bit` is 1.
- R3: In CONFIG, clearing `pd_bit` moves the sequencer to RAMP on the next clock. From the RAMP entry edge, `low_power` drops to 0.
- R4: Both mutes stay 1, and `sdout_en` stays 0, for exactly `SETTLE_CYCLES` clocks of RAMP, counted from the RAMP entry edge.
- R5: When `clk_sel_pll` is 0, RAMP goes straight to RUN. In RUN both mutes are 0 and `sdout_en` is 1.
- R6: When `clk_sel_pll` is 1, RAMP goes to WAIT_PLL. The sequencer stays in WAIT_PLL, with mutes at 1 and `sdout_en` at 0, until `pll_lock` is 1. It then enters RUN on the next clock.
- R7: In RUN with `clk_sel_pll` at 1, `sdout_en` follows `pll_lock` combinationally, while both mutes stay 0.
- R8: Setting `pd_bit` in RAMP, WAIT_PLL or RUN returns the sequencer to CONFIG on the next clock, with `low_power` at 1 and both mutes at 1. Clearing `pd_bit` again restarts the full delay.
- R9: Asserting `rst_pin_n` low in any state forces the R1 outputs at once and restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | External active-low reset (async assert) |
| pd_bit | input | 1 | Power-down control bit, 1 = stay in low power |
| pll_lock | input | 1 | PLL settled indication |
| clk_sel_pll | input | 1 | 1 = PLL is the clock source |
| regs_rst | output | 1 | Register-file reset |
| ctl_port_en | output | 1 | Control port enable |
| low_power | output | 1 | Core low-power enable |
| port_mute | output | 1 | Serial port forced mute |
| conv_mute | output | 1 | Converter output forced mute |
| sdout_en | output | 1 | Serial audio output enable |

## Verification
The bench measures the unmute edge exactly, so a delay counter that is off by one in either direction shows up as a mute released a clock early or a clock late. It sets `pd_bit` again in the middle of RAMP and then clears it. A counter that failed to restart would unmute early. It holds `pll_lock` low after the delay and drops it during RUN. A sequencer that ignored the PLL select, or latched `sdout_en`, would drive audio from an unsettled clock. Finally, it asserts reset in the middle of RUN, and any output that was not forced immediately would be caught.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        ST_RESET    = 3'd0,
        ST_CONFIG   = 3'd1,
        ST_RAMP     = 3'd2,
        ST_WAIT_PLL = 3'd3,
        ST_RUN      = 3'd4
    } seq_state_t;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 16,
    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt != CW'(SETTLE_CYCLES - 1))
            cnt <= cnt + 1'b1;
    end

    // done is high during the last RAMP cycle
    assign done = run && (cnt == CW'(SETTLE_CYCLES - 1));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(SETTLE_CYCLES - 1));
    a_r4_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_bit,
    input  logic       pll_lock,
    input  logic       clk_sel_pll,
    input  logic       settle_done,
    output seq_state_t state
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:    nxt = ST_CONFIG;
            ST_CONFIG:   if (!pd_bit) nxt = ST_RAMP;
            ST_RAMP:     if (pd_bit) nxt = ST_CONFIG;
                         else if (settle_done) nxt = clk_sel_pll ? ST_WAIT_PLL : ST_RUN;
            ST_WAIT_PLL: if (pd_bit) nxt = ST_CONFIG;
                         else if (pll_lock) nxt = ST_RUN;
            ST_RUN:      if (pd_bit) nxt = ST_CONFIG;
            default:     nxt = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    a_r3_leave_config: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIG && !pd_bit) |=> state == ST_RAMP);
    a_r8_pd_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_RAMP, ST_WAIT_PLL, ST_RUN} && pd_bit) |=> state == ST_CONFIG);
    a_r6_hold_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_PLL && !pll_lock && !pd_bit) |=> state == ST_WAIT_PLL);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned SETTLE_US = 80_000,
    parameter int unsigned SETTLE_CYCLES = (CLK_HZ / 1_000_000) * SETTLE_US
) (
    input  logic clk,
    input  logic rst_pin_n,
    input  logic pd_bit,
    input  logic pll_lock,
    input  logic clk_sel_pll,
    output logic regs_rst,
    output logic ctl_port_en,
    output logic low_power,
    output logic port_mute,
    output logic conv_mute,
    output logic sdout_en
);
    seq_state_t state;
    logic       settle_done;
    logic       ramp_active;

    assign ramp_active = (state == ST_RAMP) && !pd_bit;

    settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_pin_n),
        .run  (ramp_active),
        .done (settle_done)
    );

    pwr_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_pin_n),
        .pd_bit     (pd_bit),
        .pll_lock   (pll_lock),
        .clk_sel_pll(clk_sel_pll),
        .settle_done(settle_done),
        .state      (state)
    );

    always_comb begin
        regs_rst    = 1'b1;
        ctl_port_en = 1'b0;
        low_power   = 1'b1;
        port_mute   = 1'b1;
        conv_mute   = 1'b1;
        sdout_en    = 1'b0;
        if (rst_pin_n) begin
            unique case (state)
                ST_RESET: ;
                ST_CONFIG: begin
                    regs_rst    = 1'b0;
                    ctl_port_en = 1'b1;
                end
                ST_RAMP, ST_WAIT_PLL: begin
                    regs_rst    = 1'b0;
                    ctl_port_en = 1'b1;
                    low_power   = 1'b0;
                end
                ST_RUN: begin
                    regs_rst    = 1'b0;
                    ctl_port_en = 1'b1;
                    low_power   = 1'b0;
                    port_mute   = 1'b0;
                    conv_mute   = 1'b0;
                    sdout_en    = !clk_sel_pll || pll_lock;
                end
                default: ;
            endcase
        end
    end

    a_r1_reset_forces: assert property (@(posedge clk)
        !rst_pin_n |-> (regs_rst && low_power && port_mute && conv_mute && !sdout_en && !ctl_port_en));
    a_r4_enable_implies_unmuted: assert property (@(posedge clk) disable iff (!rst_pin_n)
        sdout_en |-> (!port_mute && !conv_mute && !low_power));
    a_r2_config_after_release: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $rose(ctl_port_en) |-> regs_rst == 1'b0);
endmodule

// File: tb/test_pwr_seq_top.sv
`timescale 1ns/1ps
module test_pwr_seq_top;
    localparam int unsigned N = 20;
    logic clk = 0, rst_pin_n = 0, pd_bit = 1, pll_lock = 0, clk_sel_pll = 0;
    logic regs_rst, ctl_port_en, low_power, port_mute, conv_mute, sdout_en;
    int vecs = 0, errs = 0;

    always #5 clk = ~clk;

    pwr_seq_top #(.SETTLE_CYCLES(N)) i_pwr_seq_top (.*);

    task automatic chk(string req, logic [5:0] exp);
        logic [5:0] act;
        act = {regs_rst, ctl_port_en, low_power, port_mute, conv_mute, sdout_en};
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %b expected %b (rst,cp,lp,pm,cm,en)", req, act, exp);
        end
    endtask

    // outputs sampled at negedge; inputs changed at negedge
    task automatic tick(int n = 1); repeat (n) @(negedge clk); endtask

    localparam logic [5:0] O_RST = 6'b101110, O_CFG = 6'b011110,
                           O_RMP = 6'b010110, O_RUN = 6'b010001, O_RUN_NOEN = 6'b010000;

    task automatic t_reset();
        rst_pin_n = 0; pd_bit = 1; tick(); chk("R1", O_RST);
        rst_pin_n = 1; tick(); chk("R2", O_CFG);
        tick(3); chk("R2", O_CFG);
    endtask

    // from CONFIG: clear pd, check unmute lands exactly after N ramp cycles
    task automatic t_ramp_direct();
        clk_sel_pll = 0; pd_bit = 0; tick();          // RAMP entered, first ramp cycle
        chk("R3", O_RMP);
        tick(N - 1); chk("R4", O_RMP);                // last ramp cycle
        tick(); chk("R5", O_RUN);
    endtask

    task automatic t_pd_restart();
        pd_bit = 1; tick(); chk("R8", O_CFG);
        pd_bit = 0; tick(N / 2);
        pd_bit = 1; tick(); chk("R8", O_CFG);
        pd_bit = 0; tick(N); chk("R8", O_RMP);        // delay restarted from zero
        tick(); chk("R8", O_RUN);
    endtask

    task automatic t_pll();
        pd_bit = 1; tick(); pd_bit = 0; clk_sel_pll = 1; pll_lock = 0;
        tick(N + 1); chk("R6", O_RMP);                // WAIT_PLL
        tick(5); chk("R6", O_RMP);
        pll_lock = 1; #1 chk("R6", O_RMP);
        tick(); chk("R6", O_RUN);
        pll_lock = 0; #1 chk("R7", O_RUN_NOEN);
        tick(); chk("R7", O_RUN_NOEN);
        pll_lock = 1; #1 chk("R7", O_RUN);
    endtask

    task automatic t_reset_midrun();
        rst_pin_n = 0; #1 chk("R9", O_RST);
        tick(); chk("R9", O_RST);
        rst_pin_n = 1; pd_bit = 1; tick(); chk("R9", O_CFG);
        pd_bit = 0; clk_sel_pll = 0; tick(N); chk("R9", O_RMP);
        tick(); chk("R9", O_RUN);
    endtask

    initial begin
        tick(2);
        t_reset();
        t_ramp_direct();
        t_pd_restart();
        t_pll();
        t_reset_midrun();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #1_000_000;
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule